// File: doc/BRIEF.md
# Booth-Wallace FIR filter datapath

A direct-form finite impulse response filter for signed fixed-point samples. Each accepted sample is multiplied by K signed coefficients, one coefficient per sample position in a short history line, and the products are summed at full precision. Every product comes from a radix-4 Booth multiplier. The coefficient side is recoded into Booth digits once, when the coefficient is written. The partial products are then reduced by a carry-save tree of full adders with no registers inside it, and a single carry-propagate add finishes each product.

A sample is accepted in a cycle where the valid strobe is high. One cycle later the filtered sum appears together with an output valid flag. In cycles without a strobe, the history line and the output register keep their values. Coefficients are written one tap at a time through a small load port. Tap 0 weights the newest sample, and tap k weights the sample accepted k strobes earlier. The output is N+M+ceil(log2 K) bits wide, so the sum can never overflow.

Top module: `fir_booth`

## Requirements
- R1: While rst_n is low on a clock edge, the next cycle shows out_valid = 0 and out_sum = 0. The reset also clears all stored coefficients and all history entries to zero.
- R2: out_valid in each cycle equals in_valid in the previous cycle.
- R3: On a clock edge with in_valid high, out_sum becomes the two's-complement sum over k = 0..K-1 of c[k]·x[k]. Here x[0] is in_sample on that edge, x[k] is the sample accepted k strobes earlier (zero if that strobe has not yet happened since reset), and c[k] is the signed coefficient of tap k.
- R4: On a clock edge with in_valid low, out_sum and the sample history are unchanged.
- R5: On an edge with coef_we high, coef_val is stored as the coefficient of tap coef_idx (binary tap number). A strobe on that same edge still uses the old coefficient, and the next strobe uses the new one.
- R6: The product of the most negative sample -2^(N-1) and the most negative coefficient -2^(M-1) is exact. With all K taps at their extreme values, out_sum stays within ±K·2^(N+M-2) and does not wrap.
- R7: A coefficient write without a strobe leaves out_sum and the history unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | N | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_idx | input | max(1,ceil(log2 K)) | Tap number to write |
| coef_val | input | M | Signed coefficient value |
| out_valid | output | 1 | Output sum valid, one cycle after in_valid |
| out_sum | output | N+M+ceil(log2 K) | Signed full-precision filter sum |

## Verification
The hardest case to reach is the one where the Booth recoding of the most negative coefficient and the sign extension of the most negative sample must combine across every tap at once, producing the largest positive and negative sums. The stimulus reaches it by loading every tap with the extreme coefficient and then filling the whole history with the extreme sample. A second case is a coefficient write on the same edge as a strobe, which separates the old and new coefficient values. Directed sequences cover an impulse, these extremes and the same-edge write. Long random runs add gaps in the strobe and interleaved writes, and a bench-side model of signed products checks every cycle.

// File: rtl/fir_booth.sv
module fir_booth #(
  parameter int N = 8,
  parameter int M = 8,
  parameter int K = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      in_valid,
  input  logic signed [N-1:0]                       in_sample,
  input  logic                                      coef_we,
  input  logic [((K > 1) ? $clog2(K) : 1)-1:0]      coef_idx,
  input  logic signed [M-1:0]                       coef_val,
  output logic                                      out_valid,
  output logic [N+M+((K > 1) ? $clog2(K) : 0)-1:0]  out_sum
);
  localparam int D  = (M + 1) / 2;
  localparam int W  = N + M + ((K > 1) ? $clog2(K) : 0);
  localparam int IW = (K > 1) ? $clog2(K) : 1;
  localparam int CW = 2 * D + 1;
  localparam int HL = (K > 1) ? K - 1 : 1;

  logic [D-1:0][2:0]   dig  [K];
  logic signed [N-1:0] hist [HL];
  logic signed [N-1:0] xs   [K];
  logic [W-1:0]        prod [K];
  logic [W-1:0]        acc;

  function automatic logic [D-1:0][2:0] recode(input logic signed [M-1:0] c);
    logic signed [M:0]    s;
    logic [CW-1:0]        e;
    logic [D-1:0][2:0]    d;
    s = {c, 1'b0};
    e = CW'(s);
    for (int j = 0; j < D; j++) begin
      d[j][0] = e[2*j] ^ e[2*j+1];
      d[j][1] = (e[2*j+2] & ~e[2*j+1] & ~e[2*j]) | (~e[2*j+2] & e[2*j+1] & e[2*j]);
      d[j][2] = e[2*j+2];
    end
    return d;
  endfunction

  function automatic logic [W-1:0] tap_mult(input logic signed [N-1:0] x,
                                            input logic [D-1:0][2:0] dg);
    logic [W-1:0]        r [D];
    logic [W-1:0]        t [D];
    logic signed [W-1:0] xw, sel;
    int n, m;
    xw = W'(x);
    for (int j = 0; j < D; j++) begin
      sel  = dg[j][0] ? xw : (dg[j][1] ? (xw <<< 1) : '0);
      r[j] = (dg[j][2] ? -sel : sel) << (2 * j);
      t[j] = '0;
    end
    n = D;
    for (int lvl = 0; lvl < D; lvl++) begin
      if (n > 2) begin
        m = 0;
        for (int i = 0; i < D; i++) begin
          if (i % 3 == 0 && i + 2 < n) begin
            t[m]   = r[i] ^ r[i+1] ^ r[i+2];
            t[m+1] = ((r[i] & r[i+1]) | (r[i] & r[i+2]) | (r[i+1] & r[i+2])) << 1;
            m      = m + 2;
          end else if (i >= (n / 3) * 3 && i < n) begin
            t[m] = r[i];
            m    = m + 1;
          end
        end
        r = t;
        n = m;
      end
    end
    return r[0] + ((n > 1) ? r[1] : '0);
  endfunction

  assign xs[0] = in_sample;
  for (genvar k = 1; k < K; k++) begin : g_tap
    assign xs[k] = hist[k-1];
  end
  for (genvar k = 0; k < K; k++) begin : g_mul
    assign prod[k] = tap_mult(xs[k], dig[k]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < K; k++) acc = acc + prod[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      for (int k = 0; k < K; k++) dig[k] <= '0;
      for (int k = 0; k < HL; k++) hist[k] <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sum <= acc;
        hist[0] <= in_sample;
        for (int k = 1; k < HL; k++) hist[k] <= hist[k-1];
      end
      for (int k = 0; k < K; k++)
        if (coef_we && coef_idx == IW'(k)) dig[k] <= recode(coef_val);
    end
  end
endmodule

// File: rtl/fir_booth_chk.sv
module fir_booth_chk #(
  parameter int N = 8,
  parameter int M = 8,
  parameter int K = 4
) (
  input logic                                      clk,
  input logic                                      rst_n,
  input logic                                      in_valid,
  input logic                                      out_valid,
  input logic [N+M+((K > 1) ? $clog2(K) : 0)-1:0]  out_sum
);
  localparam longint LIM = longint'(K) << (N + M - 2);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= rst_n;

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_sum == '0)); // R1
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n) past_ok |-> out_valid == $past(in_valid)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (past_ok && !$past(in_valid)) |-> $stable(out_sum)); // R4
  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (longint'($signed(out_sum)) <= LIM && longint'($signed(out_sum)) >= -LIM)); // R6
endmodule

bind fir_booth fir_booth_chk #(.N(N), .M(M), .K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid), .out_sum(out_sum)
);

// File: tb/fir_booth_bench.sv
`timescale 1ns/1ps
module fir_booth_bench;
  localparam int N  = 8;
  localparam int M  = 8;
  localparam int K  = 4;
  localparam int W  = N + M + $clog2(K);
  localparam int IW = $clog2(K);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [N-1:0] in_sample = '0;
  logic coef_we = 1'b0;
  logic [IW-1:0] coef_idx = '0;
  logic signed [M-1:0] coef_val = '0;
  logic out_valid;
  logic [W-1:0] out_sum;

  int checks = 0;
  int errors = 0;
  longint c [K];
  longint h [K];
  longint exp_sum = 0;

  always #2 clk = ~clk;

  fir_booth #(.N(N), .M(M), .K(K)) u_fir_booth (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_val(coef_val),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  task automatic check(string tag, longint act, longint expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic longint model_sum(longint s);
    longint e = c[0] * s;
    for (int k = 1; k < K; k++) e += c[k] * h[k-1];
    return e;
  endfunction

  task automatic step(bit v, longint s, bit we, int idx, longint cv, string tag);
    bit ev;
    @(negedge clk);
    in_valid = v; in_sample = N'(s); coef_we = we; coef_idx = IW'(idx); coef_val = M'(cv);
    @(posedge clk); #1;
    ev = v;
    if (v) begin
      exp_sum = model_sum(s);
      for (int k = K - 1; k > 0; k--) h[k] = h[k-1];
      h[0] = s;
    end
    if (we) c[idx] = cv;
    check(tag, longint'($signed(out_sum)), exp_sum);
    check("R2", longint'(out_valid), longint'(ev));
  endtask

  function automatic longint rnd(int bits);
    return longint'($urandom_range(0, (1 << bits) - 1)) - (longint'(1) << (bits - 1));
  endfunction

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < K; k++) begin c[k] = 0; h[k] = 0; end
    in_valid = 1'b1; in_sample = 8'sd55;
    repeat (3) @(posedge clk);
    #1;
    check("R1", longint'(out_valid), 0);
    check("R1", longint'($signed(out_sum)), 0);
    @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;

    step(1, 100, 0, 0, 0, "R1");
    step(1, -77, 0, 0, 0, "R1");
    for (int k = 0; k < K; k++) step(0, 0, 1, k, k + 1, "R7");
    step(1, 1, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, "R3");
    step(1, 3, 1, 0, -5, "R5");
    step(1, 3, 0, 0, 0, "R5");
    step(0, 99, 1, 2, -9, "R7");

    for (int k = 0; k < K; k++) step(0, 0, 1, k, -(1 << (M - 1)), "R7");
    step(1, -(1 << (N - 1)), 0, 0, 0, "R6");
    for (int k = 1; k < K; k++) step(1, -(1 << (N - 1)), 0, 0, 0, "R6");
    check("R6", exp_sum, longint'(K) << (N + M - 2));
    for (int k = 0; k < K; k++) step(0, 0, 1, k, (1 << (M - 1)) - 1, "R7");
    step(1, -(1 << (N - 1)), 0, 0, 0, "R6");
    step(1, (1 << (N - 1)) - 1, 1, 1, -(1 << (M - 1)), "R6");
    step(1, -(1 << (N - 1)), 0, 0, 0, "R6");

    for (int i = 0; i < 400; i++) begin
      bit v = ($urandom_range(0, 3) != 0);
      bit we = ($urandom_range(0, 7) == 0);
      step(v, rnd(N), we, $urandom_range(0, K - 1), rnd(M), v ? "R3" : (we ? "R7" : "R4"));
    end
    for (int i = 0; i < 40; i++)
      step(1, ($urandom_range(0, 1) != 0) ? -(1 << (N - 1)) : (1 << (N - 1)) - 1,
           ($urandom_range(0, 1) != 0), $urandom_range(0, K - 1),
           ($urandom_range(0, 1) != 0) ? -(1 << (M - 1)) : (1 << (M - 1)) - 1, "R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule